// File: doc/BRIEF.md
# Display Power Sequence Player

This block replays fixed lists of register writes to a display controller. Each list entry holds an 8-bit register index, a 16-bit value and a 16-bit wait in milliseconds. The block passes each entry to a separate register writer over a valid/ready/done handshake. When the writer reports that the write is finished, the block waits for the entry's own delay before it offers the next entry. The delay is counted in ticks of a 1 ms strobe that comes from outside.

After reset the player runs a configuration list and then goes straight into a list that enables the pixel interface. From then on it accepts power requests. A request carries a level and a strobe. A level above the "unblank" level plays the display-off list, and any other level plays the display-on list. A request for the level already in force causes no writes. If a request arrives while a list is playing, it is held and handled once that list is finished; only the newest held request is kept.

Top module: `dps_player`

## Requirements
- R1: While reset is high and in the cycle after it is released, `busy` is 1, `pwr_state` is 0 (the unblank level) and `wr_valid` offers the first configuration write: index 0x01, value 0x0000.
- R2: `wr_valid` stays high with stable `wr_index` and `wr_value` until `wr_ready` is seen. After acceptance no further write is offered until `wr_done` arrives.
- R3: An entry with zero delay moves on in the cycle after `wr_done`. An entry with delay D waits for D `ms_tick` pulses after `wr_done`, and moves on one cycle after the D-th pulse.
- R4: The configuration list is, as {index, value, delay ms}: {0x01,0x0000,0}, {0x13,0x0000,200}, {0x12,0x01BB,50}, {0x29,0x0010,50}, {0x07,0x0133,0}.
- R5: The interface-enable list follows the configuration list with `busy` held high. It is {0x03,0x1080,0}, {0x20,0x0000,0}, {0x21,0x0000,0}, {0x0C,0x0111,500}.
- R6: The off list is {0x07,0x0131,100}, {0x07,0x0130,100}, {0x07,0x0100,0}, {0x10,0x0280,0}, {0x12,0x018B,0}.
- R7: The on list is {0x10,0x1280,0}, {0x07,0x0101,100}, {0x07,0x0121,0}, {0x07,0x0123,100}, {0x07,0x0133,10}.
- R8: A request with a level above 0 starts the off list, and level 0 starts the on list. `pwr_state` takes the requested level in the cycle in which the first write of that list is offered. A strobe sampled while the block is idle starts the list two cycles later.
- R9: A request whose level equals `pwr_state` offers no write and leaves `busy` low.
- R10: Requests strobed before the interface-enable list has finished are dropped.
- R11: A request strobed while a list is playing is held and acted on when that list ends. A later strobe replaces an earlier held request.
- R12: `busy` is low only when no list is playing. It falls in the cycle after the last entry's wait ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| req_strobe | input | 1 | Samples `req_level` as a power request |
| req_level | input | PWR_W | Requested power level (0 = unblank) |
| pwr_state | output | PWR_W | Level currently in force |
| busy | output | 1 | A list is playing |
| wr_valid | output | 1 | A write is offered to the register writer |
| wr_index | output | 8 | Register index of the offered write |
| wr_value | output | 16 | Value of the offered write |
| wr_ready | input | 1 | The writer accepts the offered write |
| wr_done | input | 1 | The writer has finished the accepted write |

## Verification
A write is offered in the cycle after a zero-delay `wr_done`, and one cycle after the last millisecond tick of a nonzero wait. The bench drives every tick and every handshake edge itself on the falling clock. It samples right after the cycle in which each result is due, and also one tick before the end of each wait to catch an early advance. A request launches two edges after its strobe (one edge to latch it, one to launch it). `pwr_state` and the first write are therefore checked on the second falling edge after the strobe. Ignored and dropped requests are checked by watching `busy`, `wr_valid` and `pwr_state` for several cycles afterwards.

// File: rtl/dps_pkg.sv
package dps_pkg;

    localparam int IDX_W = 8;
    localparam int VAL_W = 16;
    localparam int DLY_W = 16;
    localparam int MAX_LEN = 8;
    localparam int PTR_W = $clog2(MAX_LEN);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [VAL_W-1:0] val;
        logic [DLY_W-1:0] dly;
    } cmd_t;

    typedef enum logic [1:0] {TBL_INIT, TBL_RGB, TBL_OFF, TBL_ON} tbl_e;

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DELAY} state_e;

    function automatic cmd_t mk(input logic [IDX_W-1:0] i, input logic [VAL_W-1:0] v,
                                input logic [DLY_W-1:0] d);
        cmd_t c;
        c.idx = i;
        c.val = v;
        c.dly = d;
        return c;
    endfunction

    function automatic logic [PTR_W-1:0] last_ptr(input tbl_e t);
        case (t)
            TBL_RGB: return PTR_W'(3);
            default: return PTR_W'(4);
        endcase
    endfunction

    function automatic cmd_t seq_cmd(input tbl_e t, input logic [PTR_W-1:0] p);
        cmd_t c;
        c = '0;
        case (t)
            TBL_INIT: case (p)
                3'd0:    c = mk(8'h01, 16'h0000, 16'd0);
                3'd1:    c = mk(8'h13, 16'h0000, 16'd200);
                3'd2:    c = mk(8'h12, 16'h01BB, 16'd50);
                3'd3:    c = mk(8'h29, 16'h0010, 16'd50);
                default: c = mk(8'h07, 16'h0133, 16'd0);
            endcase
            TBL_RGB: case (p)
                3'd0:    c = mk(8'h03, 16'h1080, 16'd0);
                3'd1:    c = mk(8'h20, 16'h0000, 16'd0);
                3'd2:    c = mk(8'h21, 16'h0000, 16'd0);
                default: c = mk(8'h0C, 16'h0111, 16'd500);
            endcase
            TBL_OFF: case (p)
                3'd0:    c = mk(8'h07, 16'h0131, 16'd100);
                3'd1:    c = mk(8'h07, 16'h0130, 16'd100);
                3'd2:    c = mk(8'h07, 16'h0100, 16'd0);
                3'd3:    c = mk(8'h10, 16'h0280, 16'd0);
                default: c = mk(8'h12, 16'h018B, 16'd0);
            endcase
            default: case (p)
                3'd0:    c = mk(8'h10, 16'h1280, 16'd0);
                3'd1:    c = mk(8'h07, 16'h0101, 16'd100);
                3'd2:    c = mk(8'h07, 16'h0121, 16'd0);
                3'd3:    c = mk(8'h07, 16'h0123, 16'd100);
                default: c = mk(8'h07, 16'h0133, 16'd10);
            endcase
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dps_rom.sv
module dps_rom
    import dps_pkg::*;
(
    input  tbl_e             tbl,
    input  logic [PTR_W-1:0] ptr,
    output cmd_t             cmd,
    output logic             last
);
    always_comb begin
        cmd  = seq_cmd(tbl, ptr);
        last = (ptr == last_ptr(tbl));
    end
endmodule

// File: rtl/dps_delay.sv
module dps_delay #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          tick,
    output logic          expired
);
    logic [DW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (tick && remain != '0)
            remain <= remain - 1'b1;
    end

    assign expired = (remain == '0);

    // R3: the wait only shortens on a millisecond tick
    assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(remain));
endmodule

// File: rtl/dps_req.sv
module dps_req #(
    parameter int PWR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             strobe,
    input  logic [PWR_W-1:0] level,
    input  logic             take,
    output logic             pend_valid,
    output logic [PWR_W-1:0] pend_level
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_level <= '0;
        end else if (enable && strobe) begin
            pend_valid <= 1'b1;
            pend_level <= level;
        end else if (take) begin
            pend_valid <= 1'b0;
        end
    end

    // R10: nothing is held before start-up has finished
    assert_no_req_pre_init_R10: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !pend_valid);
endmodule

// File: rtl/dps_player.sv
module dps_player
    import dps_pkg::*;
#(
    parameter int PWR_W   = 4,
    parameter int UNBLANK = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ms_tick,
    input  logic             req_strobe,
    input  logic [PWR_W-1:0] req_level,
    output logic [PWR_W-1:0] pwr_state,
    output logic             busy,
    output logic             wr_valid,
    output logic [IDX_W-1:0] wr_index,
    output logic [VAL_W-1:0] wr_value,
    input  logic             wr_ready,
    input  logic             wr_done
);
    localparam logic [PWR_W-1:0] LVL_ON = PWR_W'(UNBLANK);

    state_e           state;
    tbl_e             tbl;
    logic [PTR_W-1:0] ptr;
    logic             init_done;
    cmd_t             cmd;
    logic             last;
    logic             expired;
    logic             load;
    logic             step;
    logic             take;
    logic             pend_valid;
    logic [PWR_W-1:0] pend_level;

    dps_rom u_rom (
        .tbl  (tbl),
        .ptr  (ptr),
        .cmd  (cmd),
        .last (last)
    );

    dps_delay #(.DW(DLY_W)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (cmd.dly),
        .tick     (ms_tick),
        .expired  (expired)
    );

    dps_req #(.PWR_W(PWR_W)) u_req (
        .clk        (clk),
        .rst        (rst),
        .enable     (init_done),
        .strobe     (req_strobe),
        .level      (req_level),
        .take       (take),
        .pend_valid (pend_valid),
        .pend_level (pend_level)
    );

    always_comb begin
        load = (state == S_WAIT) && wr_done && (cmd.dly != '0);
        step = ((state == S_WAIT) && wr_done && (cmd.dly == '0)) ||
               ((state == S_DELAY) && expired);
        take = (state == S_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_ISSUE;
            tbl       <= TBL_INIT;
            ptr       <= '0;
            init_done <= 1'b0;
            pwr_state <= LVL_ON;
        end else if (step) begin
            if (!last) begin
                ptr   <= ptr + 1'b1;
                state <= S_ISSUE;
            end else if (tbl == TBL_INIT) begin
                tbl   <= TBL_RGB;
                ptr   <= '0;
                state <= S_ISSUE;
            end else begin
                init_done <= 1'b1;
                state     <= S_IDLE;
            end
        end else begin
            case (state)
                S_ISSUE: if (wr_ready) state <= S_WAIT;
                S_WAIT:  if (load) state <= S_DELAY;
                S_IDLE: begin
                    if (pend_valid && pend_level != pwr_state) begin
                        pwr_state <= pend_level;
                        tbl       <= (pend_level > LVL_ON) ? TBL_OFF : TBL_ON;
                        ptr       <= '0;
                        state     <= S_ISSUE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign wr_valid = (state == S_ISSUE);
    assign wr_index = cmd.idx;
    assign wr_value = cmd.val;
    assign busy     = (state != S_IDLE);

    // R2: an offered write holds steady until accepted
    assert_valid_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_index) && $stable(wr_value)));

    // R8: the level only changes when a list is launched
    assert_state_change_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (pwr_state != $past(pwr_state)) |-> (busy && wr_valid));

    // R11: a list only starts from a held request
    assert_launch_needs_request_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(pend_valid));
endmodule

// File: tb/test_dps_player.sv
module test_dps_player;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ms_tick = 1'b0;
    logic        req_strobe = 1'b0;
    logic [3:0]  req_level = '0;
    logic [3:0]  pwr_state;
    logic        busy;
    logic        wr_valid;
    logic [7:0]  wr_index;
    logic [15:0] wr_value;
    logic        wr_ready = 1'b0;
    logic        wr_done = 1'b0;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    dps_player #(.PWR_W(4), .UNBLANK(0)) i_dps_player (
        .clk        (clk),
        .rst        (rst),
        .ms_tick    (ms_tick),
        .req_strobe (req_strobe),
        .req_level  (req_level),
        .pwr_state  (pwr_state),
        .busy       (busy),
        .wr_valid   (wr_valid),
        .wr_index   (wr_index),
        .wr_value   (wr_value),
        .wr_ready   (wr_ready),
        .wr_done    (wr_done)
    );

    // {index, value, delay ms}: config 0..4, enable 5..8, off 9..13, on 14..18
    localparam logic [39:0] EXP [19] = '{
        {8'h01, 16'h0000, 16'd0},   {8'h13, 16'h0000, 16'd200},
        {8'h12, 16'h01BB, 16'd50},  {8'h29, 16'h0010, 16'd50},
        {8'h07, 16'h0133, 16'd0},
        {8'h03, 16'h1080, 16'd0},   {8'h20, 16'h0000, 16'd0},
        {8'h21, 16'h0000, 16'd0},   {8'h0C, 16'h0111, 16'd500},
        {8'h07, 16'h0131, 16'd100}, {8'h07, 16'h0130, 16'd100},
        {8'h07, 16'h0100, 16'd0},   {8'h10, 16'h0280, 16'd0},
        {8'h12, 16'h018B, 16'd0},
        {8'h10, 16'h1280, 16'd0},   {8'h07, 16'h0101, 16'd100},
        {8'h07, 16'h0121, 16'd0},   {8'h07, 16'h0123, 16'd100},
        {8'h07, 16'h0133, 16'd10}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    function automatic string tag_of(input int e);
        if (e < 5) return "R4";
        if (e < 9) return "R5";
        if (e < 14) return "R6";
        return "R7";
    endfunction

    task automatic strobe(input logic [3:0] lvl);
        req_level  = lvl;
        req_strobe = 1'b1;
        cyc();
        req_strobe = 1'b0;
    endtask

    task automatic play(input int first, input int last_e);
        for (int e = first; e <= last_e; e++) begin
            logic [7:0]  xi;
            logic [15:0] xv;
            int          xd;
            int          w;
            xi = EXP[e][39:32];
            xv = EXP[e][31:16];
            xd = int'(EXP[e][15:0]);
            w = 0;
            while (!wr_valid && w < 4) begin
                cyc();
                w++;
            end
            chk(wr_valid && busy, "R12", "write offered while busy", w, 0);
            chk(wr_index == xi, tag_of(e), "index", wr_index, xi);
            chk(wr_value == xv, tag_of(e), "value", wr_value, xv);
            cyc();
            chk(wr_valid && wr_index == xi && wr_value == xv, "R2", "held without ready",
                wr_value, xv);
            wr_ready = 1'b1;
            cyc();
            wr_ready = 1'b0;
            cyc();
            cyc();
            chk(!wr_valid, "R2", "no offer before done", wr_valid, 0);
            wr_done = 1'b1;
            cyc();
            wr_done = 1'b0;
            if (xd > 0) begin
                for (int k = 1; k <= xd; k++) begin
                    ms_tick = 1'b1;
                    cyc();
                    ms_tick = 1'b0;
                    cyc();
                    if (k == xd - 1)
                        chk(!wr_valid && busy, "R3", "no early advance", wr_valid, 0);
                end
            end
            chk(wr_valid || !busy, "R3", "advance right after wait", busy, 0);
            if (e == 4)
                chk(busy && wr_valid, "R5", "enable list follows without gap", busy, 1);
        end
    endtask

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        chk(busy == 1'b1, "R1", "busy in reset", busy, 1);
        chk(pwr_state == 4'd0, "R1", "level in reset", pwr_state, 0);
        rst = 1'b0;
        cyc();
        chk(wr_valid && wr_index == 8'h01 && wr_value == 16'h0000, "R1",
            "first write after reset", wr_index, 8'h01);

        play(0, 0);
        strobe(4'd3);            // R10: must be dropped
        play(1, 8);
        repeat (4) cyc();
        chk(!busy && !wr_valid, "R10", "early request dropped", busy, 0);
        chk(pwr_state == 4'd0, "R10", "level after dropped request", pwr_state, 0);

        strobe(4'd0);
        repeat (4) cyc();
        chk(!busy && !wr_valid, "R9", "matching request ignored", busy, 0);
        chk(pwr_state == 4'd0, "R9", "level unchanged", pwr_state, 0);

        strobe(4'd4);
        cyc();
        chk(busy && wr_valid && pwr_state == 4'd4, "R8", "off launched, level 4",
            pwr_state, 4);
        play(9, 9);
        strobe(4'd2);
        strobe(4'd0);            // R11: the newest request wins
        play(10, 13);
        cyc();
        chk(wr_valid && wr_value == 16'h1280 && pwr_state == 4'd0, "R11",
            "held request runs on list", wr_value, 16'h1280);
        play(14, 18);
        chk(!busy, "R12", "idle after on list", busy, 0);
        cyc();
        chk(!busy && pwr_state == 4'd0, "R11", "older held request discarded", busy, 0);

        strobe(4'd1);
        cyc();
        chk(pwr_state == 4'd1 && wr_index == 8'h07 && wr_value == 16'h0131, "R8",
            "level 1 selects off list", wr_value, 16'h0131);
        play(9, 13);
        repeat (3) cyc();
        chk(!busy && pwr_state == 4'd1, "R12", "idle after off list", busy, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule